// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Arbiter

The arbiter collects eleven pending interrupt requests arranged in six priority groups. It gives each group one of four priority levels from two 6-bit configuration vectors and selects the single request to service next. The choice is presented to the processor core as a registered grant on a valid/ready handshake. Three of the request lines are shared. Each of them is the OR of its own raw input and a set of sticky sub-source flags, which are held in a small flag bank that software clears by writing zeros.

The arbiter tracks nesting with an in-service record of levels. A grant is offered only when its level is strictly above the level currently being serviced. Accepting a grant records its level, and a one-cycle return pulse removes the highest recorded level. Back-pressure rules:
- While `grant_valid_o` is high and `grant_ready_i` is low, the offered index and level stay frozen, even if the requests change.
- The grant is consumed on a cycle where valid and ready are both high.
- After a grant is consumed, valid stays low for at least one cycle.

Top module: `irq_group_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `grant_valid_o` is 0, `svc_busy_o` is 0 and `flags_o` is all zeros.
- R2: Source index s belongs to group s/2, where index 2g is the first member and 2g+1 is the second; index 10 is the only member of group 5. The level of group g is {`prio_hi_i[g]`,`prio_lo_i[g]`}, where 3 is the highest and 0 the lowest. Among the eligible requests, the one with the highest level is granted.
- R3: Among eligible requests of equal level, the lowest source index wins. This means ascending group number first, then the first member before the second.
- R4: Source s takes part only while both `src_en_i[s]` and `glob_en_i` are 1.
- R5: A grant appears on `grant_valid_o` on the clock edge that samples the request. Index and level then hold steady until the grant is accepted with `grant_ready_i`. After acceptance, valid is low for at least one cycle.
- R6: While `svc_busy_o` is 1, a request is granted only if its level is strictly greater than `svc_level_o`. An accepted grant makes `svc_level_o` equal to its level.
- R7: A one-cycle `ret_i` pulse removes the highest in-service level. `svc_level_o` then shows the next lower recorded level, or `svc_busy_o` drops to 0 when no level remains.
- R8: Flag bits are set by `flag_set_i` and stay set. A write with `flag_wr_en_i` clears every flag whose `flag_wr_data_i` bit is 0 and leaves the flags whose data bit is 1 unchanged. A set in the same cycle as a clear wins. Re-setting a flag, such as the push-button flag (bit 9), works after it has been cleared.
- R9: Flags are routed as follows:
  - bits 0, 1 and 2 (transfer-busy, one-second tick, watchdog near-overflow) are ORed onto source 10;
  - bits 3, 4 and 5 (SPI, write-collision 0, write-collision 1) are ORed onto source 3;
  - bits 6 and 7 (lock rise, lock fall) are ORed onto source 7;
  - bits 8 (wake) and 9 (push-button) drive no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 11 | Raw request lines, one per source index |
| src_en_i | input | 11 | Per-source enable |
| glob_en_i | input | 1 | Global enable |
| prio_lo_i | input | 6 | Low bit of each group's level |
| prio_hi_i | input | 6 | High bit of each group's level |
| flag_set_i | input | 10 | Hardware set pulses for the sticky flags |
| flag_wr_en_i | input | 1 | Flag write strobe |
| flag_wr_data_i | input | 10 | Flag write data (0 clears, 1 keeps) |
| grant_valid_o | output | 1 | Grant offered |
| grant_ready_i | input | 1 | Core accepts the grant |
| grant_idx_o | output | 4 | Source index of the grant |
| grant_level_o | output | 2 | Level of the grant |
| ret_i | input | 1 | Return-from-interrupt pulse |
| svc_busy_o | output | 1 | At least one level in service |
| svc_level_o | output | 2 | Highest level in service |
| flags_o | output | 10 | Sticky flag state |

## Verification
If the in-service record holds the wrong state, the next grant is either withheld or offered at a level that is not strictly higher. It can also show up as a wrong `svc_level_o` on the cycle after an accept or return. A wrong level decode or a wrong scan order shows up as the wrong `grant_idx_o` on the first grant after the stimulus. A flag bank that loses or keeps bits incorrectly shows up on `flags_o` one edge after the write. It also shows up one edge later as a grant appearing, or failing to appear, on the routed source.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int GROUPS = 6;
  localparam int MEMBERS = 2;
  localparam int SRC = GROUPS * MEMBERS - 1;
  localparam int IDX_W = $clog2(SRC);
  localparam int LEVELS = 4;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int FLAGS = 10;

  // flag positions
  localparam int F_XFER = 0;
  localparam int F_TICK = 1;
  localparam int F_WDOG = 2;
  localparam int F_SPI  = 3;
  localparam int F_COL0 = 4;
  localparam int F_COL1 = 5;
  localparam int F_LKR  = 6;
  localparam int F_LKF  = 7;
  localparam int F_WAKE = 8;
  localparam int F_BTN  = 9;

  // shared source lines
  localparam int S_SHARED_A = 3;
  localparam int S_SHARED_B = 7;
  localparam int S_SHARED_C = 10;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLAGS-1:0] set_i,
  input  logic             wr_en_i,
  input  logic [FLAGS-1:0] wr_data_i,
  output logic [FLAGS-1:0] flags_o,
  output logic             line_a_o,
  output logic             line_b_o,
  output logic             line_c_o
);
  logic [FLAGS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (wr_en_i ? (flags_q & wr_data_i) : flags_q) | set_i;
  end

  assign flags_o  = flags_q;
  assign line_a_o = flags_q[F_SPI] | flags_q[F_COL0] | flags_q[F_COL1];
  assign line_b_o = flags_q[F_LKR] | flags_q[F_LKF];
  assign line_c_o = flags_q[F_XFER] | flags_q[F_TICK] | flags_q[F_WDOG];
endmodule

// File: rtl/irq_level_picker.sv
module irq_level_picker
  import irq_arb_pkg::*;
(
  input  logic [SRC-1:0]    act_i,
  input  logic [GROUPS-1:0] prio_lo_i,
  input  logic [GROUPS-1:0] prio_hi_i,
  output logic              any_o,
  output idx_t              idx_o,
  output lvl_t              lvl_o
);
  lvl_t cand;

  // ascending scan with strict compare: lowest index wins a tie
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    cand  = '0;
    for (int s = 0; s < SRC; s++) begin
      cand = {prio_hi_i[s / MEMBERS], prio_lo_i[s / MEMBERS]};
      if (act_i[s] && (!any_o || cand > lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(s);
        lvl_o = cand;
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output logic busy_o,
  output lvl_t top_o
);
  logic [LEVELS-1:0] mask_q;
  logic [LEVELS-1:0] mask_d;

  always_comb begin
    top_o = '0;
    for (int l = 0; l < LEVELS; l++)
      if (mask_q[l]) top_o = LVL_W'(l);
  end

  assign busy_o = |mask_q;

  always_comb begin
    mask_d = mask_q;
    if (pop_i && busy_o) mask_d[top_o] = 1'b0;
    if (push_i)          mask_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC-1:0]    req_i,
  input  logic [SRC-1:0]    src_en_i,
  input  logic              glob_en_i,
  input  logic [GROUPS-1:0] prio_lo_i,
  input  logic [GROUPS-1:0] prio_hi_i,
  input  logic [FLAGS-1:0]  flag_set_i,
  input  logic              flag_wr_en_i,
  input  logic [FLAGS-1:0]  flag_wr_data_i,
  output logic              grant_valid_o,
  input  logic              grant_ready_i,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic [LVL_W-1:0]  grant_level_o,
  input  logic              ret_i,
  output logic              svc_busy_o,
  output logic [LVL_W-1:0]  svc_level_o,
  output logic [FLAGS-1:0]  flags_o
);
  logic           line_a, line_b, line_c;
  logic [SRC-1:0] merged, act;
  logic           pick_any, win;
  idx_t           pick_idx;
  lvl_t           pick_lvl;
  logic           gv_q;
  idx_t           gi_q;
  lvl_t           gl_q;
  logic           accept;

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set_i), .wr_en_i(flag_wr_en_i),
    .wr_data_i(flag_wr_data_i), .flags_o(flags_o),
    .line_a_o(line_a), .line_b_o(line_b), .line_c_o(line_c)
  );

  always_comb begin
    merged = req_i;
    merged[S_SHARED_A] = req_i[S_SHARED_A] | line_a;
    merged[S_SHARED_B] = req_i[S_SHARED_B] | line_b;
    merged[S_SHARED_C] = req_i[S_SHARED_C] | line_c;
  end

  assign act = merged & src_en_i & {SRC{glob_en_i}};

  irq_level_picker u_pick (
    .act_i(act), .prio_lo_i(prio_lo_i), .prio_hi_i(prio_hi_i),
    .any_o(pick_any), .idx_o(pick_idx), .lvl_o(pick_lvl)
  );

  assign win    = pick_any && (!svc_busy_o || pick_lvl > svc_level_o);
  assign accept = gv_q && grant_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
      gi_q <= '0;
      gl_q <= '0;
    end else if (!gv_q) begin
      gv_q <= win;
      if (win) begin
        gi_q <= pick_idx;
        gl_q <= pick_lvl;
      end
    end else if (grant_ready_i) begin
      gv_q <= 1'b0;
    end
  end

  irq_svc_stack u_svc (
    .clk(clk), .rst_n(rst_n), .push_i(accept), .push_lvl_i(gl_q),
    .pop_i(ret_i), .busy_o(svc_busy_o), .top_o(svc_level_o)
  );

  assign grant_valid_o = gv_q;
  assign grant_idx_o   = gi_q;
  assign grant_level_o = gl_q;
endmodule

// File: rtl/irq_group_arbiter_chk.sv
module irq_group_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             glob_en_i,
  input logic             flag_wr_en_i,
  input logic             grant_valid_o,
  input logic             grant_ready_i,
  input logic [IDX_W-1:0] grant_idx_o,
  input logic [LVL_W-1:0] grant_level_o,
  input logic             ret_i,
  input logic             svc_busy_o,
  input logic [LVL_W-1:0] svc_level_o,
  input logic [FLAGS-1:0] flags_o
);
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && !grant_ready_i |=> grant_valid_o && $stable(grant_idx_o) && $stable(grant_level_o)); // R5

  AST_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && svc_busy_o |-> grant_level_o > svc_level_o); // R6

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid_o) |-> $past(glob_en_i)); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr_en_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R8

  AST_RETURN_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && svc_busy_o && !(grant_valid_o && grant_ready_i)
      |=> (!svc_busy_o || svc_level_o < $past(svc_level_o))); // R7
endmodule

bind irq_group_arbiter irq_group_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .glob_en_i(glob_en_i), .flag_wr_en_i(flag_wr_en_i),
  .grant_valid_o(grant_valid_o), .grant_ready_i(grant_ready_i),
  .grant_idx_o(grant_idx_o), .grant_level_o(grant_level_o), .ret_i(ret_i),
  .svc_busy_o(svc_busy_o), .svc_level_o(svc_level_o), .flags_o(flags_o)
);

// File: tb/irq_group_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_group_arbiter_tb_top;
  import irq_arb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SRC-1:0] req = '0;
  logic [SRC-1:0] src_en = '1;
  logic glob_en = 1'b1;
  logic [GROUPS-1:0] prio_lo = '0, prio_hi = '0;
  logic [FLAGS-1:0] fset = '0, fwd = '0;
  logic fwe = 1'b0;
  logic gv, gready = 1'b1, ret = 1'b0, busy;
  logic [IDX_W-1:0] gidx;
  logic [LVL_W-1:0] glvl, slvl;
  logic [FLAGS-1:0] flags;

  int checks = 0, fails = 0, pops = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  irq_group_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .src_en_i(src_en), .glob_en_i(glob_en),
    .prio_lo_i(prio_lo), .prio_hi_i(prio_hi), .flag_set_i(fset),
    .flag_wr_en_i(fwe), .flag_wr_data_i(fwd), .grant_valid_o(gv),
    .grant_ready_i(gready), .grant_idx_o(gidx), .grant_level_o(glvl),
    .ret_i(ret), .svc_busy_o(busy), .svc_level_o(slvl), .flags_o(flags)
  );

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic expect_grant(string r, int idx, int lvl);
    exp_q.push_back(idx * 4 + lvl);
    tag_q.push_back(r);
  endtask

  // monitor: compare every accepted grant against the scoreboard
  always @(negedge clk) begin
    if (rst_n && gv && gready) begin
      pops++;
      if (exp_q.size() == 0) chk("unexpected grant", int'(gidx) * 4 + int'(glvl), -1);
      else begin
        string t;
        int e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        chk(t, int'(gidx) * 4 + int'(glvl), e);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_pops(string r, int target);
    int t = 0;
    while (pops < target && t < 100) begin
      @(posedge clk);
      t++;
    end
    #2;
    chk({r, " grant seen"}, pops >= target, 1);
  endtask

  task automatic ret_pulse();
    ret = 1'b1;
    step();
    ret = 1'b0;
  endtask

  task automatic check_now(string r, int act, int exp);
    @(negedge clk);
    chk(r, act, exp);
    step();
  endtask

  task automatic serve(string r, logic [SRC-1:0] m, int idx, int lvl);
    int target;
    target = pops + 1;
    expect_grant(r, idx, lvl);
    req = m;
    wait_pops(r, target);
    req = '0;
    ret_pulse();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int target;
    // group levels: g0=0 g1=1 g2=2 g3=3 g4=1 g5=2
    prio_hi = 6'b101100;
    prio_lo = 6'b011010;
    step(3);
    @(negedge clk);
    chk("R1 valid in reset", gv, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 flags in reset", int'(flags), 0);
    rst_n = 1'b1;
    check_now("R1 valid after reset", gv, 0);

    // R2: highest level wins
    serve("R2 g3 over g0", 11'b00001000001, 6, 3);
    serve("R2 g5 over g4", 11'b10100000000, 10, 2);
    // R3: ties
    serve("R3 first member", 11'b10000110000, 4, 2);
    serve("R3 second member", 11'b10000100000, 5, 2);
    serve("R3 lower group", 11'b00100001100, 2, 1);

    // R4: gating
    src_en[6] = 1'b0;
    serve("R4 disabled source skipped", 11'b00001000001, 0, 0);
    src_en[6] = 1'b1;
    glob_en = 1'b0;
    req = 11'b00000000100;
    step(5);
    check_now("R4 global disable", gv, 0);
    req = '0;
    glob_en = 1'b1;
    serve("R4 global enable", 11'b00000000100, 2, 1);

    // R5 hold, then nesting R6/R7
    gready = 1'b0;
    req = 11'b00100000000;
    step(2);
    @(negedge clk);
    chk("R5 valid while stalled", gv, 1);
    chk("R5 index while stalled", gidx, 8);
    step();
    req = 11'b00001000000;
    step(3);
    @(negedge clk);
    chk("R5 index frozen", gidx, 8);
    chk("R5 level frozen", glvl, 1);
    step();
    target = pops + 2;
    expect_grant("R5 stalled grant", 8, 1);
    expect_grant("R6 preempting grant", 6, 3);
    gready = 1'b1;
    wait_pops("R6", target);
    req = '0;
    check_now("R6 service level", slvl, 3);
    ret_pulse();
    @(negedge clk);
    chk("R7 pop to lower", slvl, 1);
    chk("R7 still busy", busy, 1);
    step();
    ret_pulse();
    check_now("R7 empty", busy, 0);

    // R6 blocking
    target = pops + 1;
    expect_grant("R6 base", 4, 2);
    req = 11'b00000010000;
    wait_pops("R6 base", target);
    req = 11'b00000000100;
    step(5);
    check_now("R6 lower blocked", gv, 0);
    req = 11'b00000010000;
    step(5);
    check_now("R6 equal blocked", gv, 0);
    target = pops + 1;
    expect_grant("R6 higher preempts", 6, 3);
    req = 11'b00001000100;
    wait_pops("R6 higher", target);
    req = 11'b00000000100;
    ret_pulse();
    check_now("R7 back to 2", slvl, 2);
    target = pops + 1;
    expect_grant("R7 pending after pops", 2, 1);
    ret_pulse();
    wait_pops("R7 pending", target);
    req = '0;
    ret_pulse();
    check_now("R7 idle", busy, 0);

    // R8 flags
    fset[F_WAKE] = 1'b1;
    step();
    fset = '0;
    check_now("R8 set", flags[F_WAKE], 1);
    step(3);
    check_now("R8 sticky", flags[F_WAKE], 1);
    fwe = 1'b1;
    fwd = '1;
    step();
    fwe = 1'b0;
    check_now("R8 write one no effect", flags[F_WAKE], 1);
    check_now("R9 wake routes nowhere", gv, 0);
    fwe = 1'b1;
    fwd = '1;
    fwd[F_WAKE] = 1'b0;
    step();
    fwe = 1'b0;
    check_now("R8 write zero clears", flags[F_WAKE], 0);
    fset[F_BTN] = 1'b1;
    fwe = 1'b1;
    fwd = '0;
    step();
    fset = '0;
    fwe = 1'b0;
    check_now("R8 set beats clear", int'(flags), 1 << F_BTN);
    fwe = 1'b1;
    step();
    fwe = 1'b0;
    check_now("R8 button cleared", flags[F_BTN], 0);
    fset[F_BTN] = 1'b1;
    step();
    fset = '0;
    check_now("R8 button set again", flags[F_BTN], 1);
    fwe = 1'b1;
    step();
    fwe = 1'b0;

    // R9 routing
    target = pops + 1;
    expect_grant("R9 tick flag to source 10", 10, 2);
    fset[F_TICK] = 1'b1;
    step();
    fset = '0;
    wait_pops("R9 tick", target);
    fwe = 1'b1;
    fwd = '0;
    step();
    fwe = 1'b0;
    ret_pulse();
    target = pops + 2;
    expect_grant("R9 lock flag to source 7", 7, 3);
    expect_grant("R9 spi flag to source 3", 3, 1);
    fset[F_LKF] = 1'b1;
    fset[F_SPI] = 1'b1;
    step();
    fset = '0;
    wait_pops("R9 lock", target - 1);
    fwe = 1'b1;
    fwd = '1;
    fwd[F_LKF] = 1'b0;
    step();
    fwe = 1'b0;
    ret_pulse();
    wait_pops("R9 spi", target);
    fwe = 1'b1;
    fwd = '0;
    step();
    fwe = 1'b0;
    ret_pulse();
    step(3);
    check_now("R9 all quiet", gv, 0);
    chk("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule